// File: doc/BRIEF.md
# Per-Channel Tagged FIFO Pair with DMA Request Steering

This block sits between one serial channel's shifters and the system side. It holds a receive queue and a transmit queue, each four entries deep by default. Every receive entry keeps the received character together with its status bits. Every transmit entry keeps the character together with the command bits that the transmit shifter acts on. The CPU reads and writes the queues directly. A DMA controller reaches them through single-address transfers, and the asserted acknowledge input decides which queue a transfer strobe touches.

Two active-low request pins serve a DMA controller. In half-duplex mode one pin serves whichever direction is enabled. In full-duplex mode each direction has its own pin. With DMA off, both pins are plain outputs that software drives. A separate hold output tells the far end to stop sending while the local receive queue is full. Illegal accesses are dropped, and each kind leaves a sticky error flag.

Top module: `sfd_chan_fifo`

## Requirements
- R1: Each queue holds up to DEPTH (4) entries and returns them in arrival order. A push into a full queue is dropped and leaves the contents unchanged.
- R2: A receive entry reads back as `cpu_rdata` (character) and `cpu_rstat` (status). A transmit entry reads back as `tx_pop_data` (character) and `tx_pop_cmd` (command). Both are shown at the head while the queue is not empty.
- R3: With `xfer_mode` = 2'b01 (half-duplex DMA), `req0_n` is low exactly when either of these holds: `rx_en` is high and the receive queue is not empty, or `rx_en` is low, `tx_en` is high and the transmit queue is not full. `req1_n` follows `gpo[1]`.
- R4: With `xfer_mode` = 2'b10 (full-duplex DMA), `req0_n` is low exactly when `rx_en` is high and the receive queue is not empty. `req1_n` is low exactly when `tx_en` is high and the transmit queue is not full.
- R5: With `xfer_mode` = 2'b00 or 2'b11 (no DMA), `req0_n` equals `gpo[0]` and `req1_n` equals `gpo[1]`.
- R6: `remote_hold` is high exactly while the receive queue holds DEPTH entries. `rx_full` reports the same condition to the shifter.
- R7: A write to a full transmit queue is ignored and sets `err_ovf`. A read of an empty receive queue is ignored and sets `err_udf`. Both flags stay set until an `err_clr` cycle, and a new error in that same cycle wins over the clear.
- R8: A cycle with `dma_xfer` high and `dack_rx_n` low pops the receive queue. With `dma_xfer` high, `dack_rx_n` high and `dack_tx_n` low, it pushes `bus_wdata`/`bus_wcmd` into the transmit queue. With both acknowledges high, it does nothing.
- R9: After reset both queues are empty (`tx_empty` high, `rx_full` low) and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xfer_mode | input | 2 | 01 half-duplex DMA, 10 full-duplex DMA, otherwise no DMA |
| rx_en | input | 1 | Receiver enabled |
| tx_en | input | 1 | Transmitter enabled |
| gpo | input | 2 | Software levels for the request pins |
| rx_push | input | 1 | Receive shifter delivers an entry |
| rx_push_data | input | DATA_W | Received character |
| rx_push_stat | input | STAT_W | Status bits of that character |
| rx_full | output | 1 | Receive queue full |
| tx_pop | input | 1 | Transmit shifter takes the head entry |
| tx_pop_data | output | DATA_W | Head transmit character |
| tx_pop_cmd | output | CMD_W | Head transmit command bits |
| tx_empty | output | 1 | Transmit queue empty |
| cpu_rd | input | 1 | CPU reads (pops) the receive queue |
| cpu_wr | input | 1 | CPU writes (pushes) the transmit queue |
| bus_wdata | input | DATA_W | Write character (CPU or DMA) |
| bus_wcmd | input | CMD_W | Write command bits (CPU or DMA) |
| cpu_rdata | output | DATA_W | Head receive character, zero when empty |
| cpu_rstat | output | STAT_W | Head receive status, zero when empty |
| dma_xfer | input | 1 | Single-address DMA transfer strobe |
| dack_rx_n | input | 1 | Active-low acknowledge selecting the receive queue |
| dack_tx_n | input | 1 | Active-low acknowledge selecting the transmit queue |
| err_clr | input | 1 | Clears the sticky error flags |
| err_ovf | output | 1 | Sticky: write to full transmit queue |
| err_udf | output | 1 | Sticky: read of empty receive queue |
| req0_n | output | 1 | Request pin 0, active low |
| req1_n | output | 1 | Request pin 1, active low |
| remote_hold | output | 1 | Stop the remote transmitter |

## Verification
The bench uses the default parameters: DEPTH 4, 8-bit characters, 4 status bits and 3 command bits. The queues are that shallow, so random traffic often pushes both of them to full and to empty. That makes dropped pushes, ignored reads, `remote_hold` edges and every request-pin mode likely within a few thousand cycles. Mode changes every fifty cycles and random acknowledge patterns cover all three request meanings and both DMA steering paths. Directed sequences force overflow, underflow, the clear/set race and the case where both acknowledges are asserted.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   typedef enum logic [1:0] {
      XFER_OFF     = 2'b00,
      XFER_HALF    = 2'b01,
      XFER_FULL    = 2'b10,
      XFER_OFF_ALT = 2'b11
   } xfer_mode_t;
endpackage

// File: rtl/sfd_tag_fifo.sv
module sfd_tag_fifo #(
   parameter int WIDTH = 12,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("sfd_tag_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("sfd_tag_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;
   logic             do_push, do_pop;

   function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = slot[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) slot[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= step_ptr(wr_ptr);
         if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R1
   AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wr_ptr))); // R1
   AST_EMPTY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rd_ptr))); // R7
endmodule

// File: rtl/sfd_req_mux.sv
module sfd_req_mux
   import sfd_pkg::*;
(
   input  xfer_mode_t mode,
   input  logic       rx_en,
   input  logic       tx_en,
   input  logic       rx_empty,
   input  logic       tx_full,
   input  logic [1:0] gpo,
   output logic       req0_n,
   output logic       req1_n
);
   logic rx_want, tx_want;

   assign rx_want = rx_en & ~rx_empty;
   assign tx_want = tx_en & ~tx_full;

   always_comb begin
      case (mode)
         XFER_HALF: begin
            req0_n = ~(rx_en ? rx_want : tx_want);
            req1_n = gpo[1];
         end
         XFER_FULL: begin
            req0_n = ~rx_want;
            req1_n = ~tx_want;
         end
         default: begin
            req0_n = gpo[0];
            req1_n = gpo[1];
         end
      endcase
   end
endmodule

// File: rtl/sfd_chan_fifo.sv
module sfd_chan_fifo
   import sfd_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STAT_W = 4,
   parameter int CMD_W  = 3,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        xfer_mode,
   input  logic              rx_en,
   input  logic              tx_en,
   input  logic [1:0]        gpo,
   input  logic              rx_push,
   input  logic [DATA_W-1:0] rx_push_data,
   input  logic [STAT_W-1:0] rx_push_stat,
   output logic              rx_full,
   input  logic              tx_pop,
   output logic [DATA_W-1:0] tx_pop_data,
   output logic [CMD_W-1:0]  tx_pop_cmd,
   output logic              tx_empty,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CMD_W-1:0]  bus_wcmd,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic [STAT_W-1:0] cpu_rstat,
   input  logic              dma_xfer,
   input  logic              dack_rx_n,
   input  logic              dack_tx_n,
   input  logic              err_clr,
   output logic              err_ovf,
   output logic              err_udf,
   output logic              req0_n,
   output logic              req1_n,
   output logic              remote_hold
);
   localparam int RXW = DATA_W + STAT_W;
   localparam int TXW = DATA_W + CMD_W;

   generate
      if (DATA_W < 5 || DATA_W > 16) begin : g_bad_data
         $error("sfd_chan_fifo: DATA_W out of range");
      end
      if (STAT_W < 1 || CMD_W < 1) begin : g_bad_tags
         $error("sfd_chan_fifo: tag widths must be positive");
      end
   endgenerate

   logic           rx_empty, tx_full;
   logic           rx_rd_req, tx_wr_req;
   logic [RXW-1:0] rx_head;
   logic [TXW-1:0] tx_head;

   assign rx_rd_req = cpu_rd | (dma_xfer & ~dack_rx_n);
   assign tx_wr_req = cpu_wr | (dma_xfer & dack_rx_n & ~dack_tx_n);

   sfd_tag_fifo #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data ({rx_push_stat, rx_push_data}),
      .pop       (rx_rd_req),
      .head      (rx_head),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   sfd_tag_fifo #(.WIDTH(TXW), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tx_wr_req),
      .push_data ({bus_wcmd, bus_wdata}),
      .pop       (tx_pop),
      .head      (tx_head),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   assign cpu_rdata   = rx_empty ? '0 : rx_head[DATA_W-1:0];
   assign cpu_rstat   = rx_empty ? '0 : rx_head[RXW-1:DATA_W];
   assign tx_pop_data = tx_head[DATA_W-1:0];
   assign tx_pop_cmd  = tx_head[TXW-1:DATA_W];
   assign remote_hold = rx_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_ovf <= 1'b0;
         err_udf <= 1'b0;
      end else begin
         err_ovf <= (err_ovf & ~err_clr) | (tx_wr_req & tx_full);
         err_udf <= (err_udf & ~err_clr) | (rx_rd_req & rx_empty);
      end
   end

   sfd_req_mux u_req (
      .mode     (xfer_mode_t'(xfer_mode)),
      .rx_en    (rx_en),
      .tx_en    (tx_en),
      .rx_empty (rx_empty),
      .tx_full  (tx_full),
      .gpo      (gpo),
      .req0_n   (req0_n),
      .req1_n   (req1_n)
   );

   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (remote_hold && !rx_rd_req) |=> remote_hold); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovf && !err_clr) |=> err_ovf); // R7
   AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && rx_empty) |=> err_udf); // R7
   AST_HALF_RX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_mode == 2'b01 && rx_en && !rx_empty) |-> !req0_n); // R3
   AST_FULL_TX_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_mode == 2'b10 && tx_en && !tx_full) |-> !req1_n); // R4
endmodule

// File: tb/sfd_chan_fifo_test.sv
`timescale 1ns/1ps
module sfd_chan_fifo_test;
   localparam int DEPTH = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] xfer_mode = 2'b00;
   logic       rx_en = 0, tx_en = 0;
   logic [1:0] gpo = 2'b00;
   logic       rx_push = 0;
   logic [7:0] rx_push_data = 0;
   logic [3:0] rx_push_stat = 0;
   logic       rx_full;
   logic       tx_pop = 0;
   logic [7:0] tx_pop_data;
   logic [2:0] tx_pop_cmd;
   logic       tx_empty;
   logic       cpu_rd = 0, cpu_wr = 0;
   logic [7:0] bus_wdata = 0;
   logic [2:0] bus_wcmd = 0;
   logic [7:0] cpu_rdata;
   logic [3:0] cpu_rstat;
   logic       dma_xfer = 0, dack_rx_n = 1, dack_tx_n = 1;
   logic       err_clr = 0;
   logic       err_ovf, err_udf, req0_n, req1_n, remote_hold;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   logic [11:0] rxq[$];
   logic [10:0] txq[$];
   logic        m_ovf = 0, m_udf = 0;

   always #4 clk = ~clk;

   sfd_chan_fifo uut (
      .clk(clk), .rst_n(rst_n), .xfer_mode(xfer_mode), .rx_en(rx_en), .tx_en(tx_en),
      .gpo(gpo), .rx_push(rx_push), .rx_push_data(rx_push_data),
      .rx_push_stat(rx_push_stat), .rx_full(rx_full), .tx_pop(tx_pop),
      .tx_pop_data(tx_pop_data), .tx_pop_cmd(tx_pop_cmd), .tx_empty(tx_empty),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .bus_wdata(bus_wdata), .bus_wcmd(bus_wcmd),
      .cpu_rdata(cpu_rdata), .cpu_rstat(cpu_rstat), .dma_xfer(dma_xfer),
      .dack_rx_n(dack_rx_n), .dack_tx_n(dack_tx_n), .err_clr(err_clr),
      .err_ovf(err_ovf), .err_udf(err_udf), .req0_n(req0_n), .req1_n(req1_n),
      .remote_hold(remote_hold)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_req(input logic [1:0] m, input logic re,
                                          input logic te, input int rxn,
                                          input int txn, input logic [1:0] g);
      logic r0, r1;
      case (m)
         2'b01: begin r0 = ~(re ? (rxn > 0) : (te && txn < DEPTH)); r1 = g[1]; end
         2'b10: begin r0 = ~(re && rxn > 0); r1 = ~(te && txn < DEPTH); end
         default: begin r0 = g[0]; r1 = g[1]; end
      endcase
      return {r1, r0};
   endfunction

   task automatic check_outputs();
      logic [1:0] er;
      er = exp_req(xfer_mode, rx_en, tx_en, rxq.size(), txq.size(), gpo);
      if (xfer_mode == 2'b01) chk("R3 req0_n", req0_n, er[0]);
      else if (xfer_mode == 2'b10) chk("R4 req0_n", req0_n, er[0]);
      else chk("R5 req0_n", req0_n, er[0]);
      if (xfer_mode == 2'b10) chk("R4 req1_n", req1_n, er[1]);
      else chk("R5 req1_n", req1_n, er[1]);
      chk("R6 remote_hold", remote_hold, rxq.size() == DEPTH);
      chk("R6 rx_full", rx_full, rxq.size() == DEPTH);
      chk("R1 tx_empty", tx_empty, txq.size() == 0);
      chk("R7 err_ovf", err_ovf, m_ovf);
      chk("R7 err_udf", err_udf, m_udf);
      if (rxq.size() > 0) begin
         chk("R2 cpu_rdata", cpu_rdata, rxq[0][7:0]);
         chk("R2 cpu_rstat", cpu_rstat, rxq[0][11:8]);
      end
      if (txq.size() > 0) begin
         chk("R2 tx_pop_data", tx_pop_data, txq[0][7:0]);
         chk("R2 tx_pop_cmd", tx_pop_cmd, txq[0][10:8]);
      end
   endtask

   // inputs already driven after a negedge; check, clock, update model (R8 steering)
   task automatic tick();
      int  rx_old, tx_old;
      logic rd_req, wr_req;
      #1 check_outputs();
      @(posedge clk);
      rd_req = cpu_rd | (dma_xfer & ~dack_rx_n);
      wr_req = cpu_wr | (dma_xfer & dack_rx_n & ~dack_tx_n);
      rx_old = rxq.size();
      tx_old = txq.size();
      if (err_clr) begin m_ovf = 0; m_udf = 0; end
      if (rd_req) begin
         if (rx_old == 0) m_udf = 1;
         else void'(rxq.pop_front());
      end
      if (rx_push && rx_old < DEPTH) rxq.push_back({rx_push_stat, rx_push_data});
      if (tx_pop && tx_old > 0) void'(txq.pop_front());
      if (wr_req) begin
         if (tx_old == DEPTH) m_ovf = 1;
         else txq.push_back({bus_wcmd, bus_wdata});
      end
      @(negedge clk);
   endtask

   task automatic idle();
      rx_push = 0; tx_pop = 0; cpu_rd = 0; cpu_wr = 0;
      dma_xfer = 0; dack_rx_n = 1; dack_tx_n = 1; err_clr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9 reset state
      chk("R9 tx_empty", tx_empty, 1'b1);
      chk("R9 rx_full", rx_full, 1'b0);
      chk("R9 err_ovf", err_ovf, 1'b0);
      chk("R9 err_udf", err_udf, 1'b0);
      rst_n = 1;
      @(negedge clk);

      // R7 underflow: read empty receive queue
      idle(); cpu_rd = 1; tick();
      idle(); tick();
      chk("R7 udf after empty read", err_udf, 1'b1);
      // R1/R7 overflow: five CPU writes, fifth dropped
      for (int i = 0; i < 5; i++) begin
         idle(); cpu_wr = 1; bus_wdata = 8'h10 + 8'(i); bus_wcmd = 3'(i); tick();
      end
      idle(); tick();
      chk("R1 tx head after overflow", tx_pop_data, 8'h10);
      chk("R7 ovf after full write", err_ovf, 1'b1);
      // R7 clear and new error in same cycle: set wins
      idle(); err_clr = 1; cpu_wr = 1; tick();
      idle(); tick();
      chk("R7 set wins over clear", err_ovf, 1'b1);
      chk("R7 udf cleared", err_udf, 1'b0);
      // R8 both acks high: no effect
      idle(); dma_xfer = 1; tick();
      idle(); tick();
      chk("R8 no ack leaves tx full", tx_empty, 1'b0);
      // R8 rx ack takes precedence over tx ack
      idle(); rx_push = 1; rx_push_data = 8'hA5; rx_push_stat = 4'h9; tick();
      idle(); dma_xfer = 1; dack_rx_n = 0; dack_tx_n = 0; tick();
      idle(); tick();
      chk("R8 rx ack popped rx", rx_full, 1'b0);
      // drain tx
      for (int i = 0; i < 4; i++) begin idle(); tx_pop = 1; tick(); end
      idle(); err_clr = 1; tick();
      // R6 fill receive queue to full
      xfer_mode = 2'b10; rx_en = 1; tx_en = 1;
      for (int i = 0; i < 5; i++) begin
         idle(); rx_push = 1; rx_push_data = 8'hC0 + 8'(i); rx_push_stat = 4'(i); tick();
      end
      idle(); tick();
      chk("R6 hold when full", remote_hold, 1'b1);
      chk("R1 rx head order", cpu_rdata, 8'hC0);

      // constrained random
      for (int cyc = 0; cyc < 6000; cyc++) begin
         idle();
         if (cyc % 50 == 0) xfer_mode = 2'($urandom_range(0, 3));
         rx_en = ($urandom_range(0, 3) != 0);
         tx_en = ($urandom_range(0, 3) != 0);
         gpo = 2'($urandom_range(0, 3));
         rx_push = ($urandom_range(0, 2) == 0);
         rx_push_data = 8'($urandom);
         rx_push_stat = 4'($urandom);
         tx_pop = ($urandom_range(0, 2) == 0);
         bus_wdata = 8'($urandom);
         bus_wcmd = 3'($urandom);
         case ($urandom_range(0, 5))
            0: cpu_rd = 1;
            1: cpu_wr = 1;
            2: begin dma_xfer = 1; dack_rx_n = 0; dack_tx_n = 1'($urandom); end
            3: begin dma_xfer = 1; dack_tx_n = 0; end
            4: dma_xfer = 1;
            default: ;
         endcase
         err_clr = ($urandom_range(0, 30) == 0);
         tick();
      end
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule